// File: doc/BRIEF.md
# Paged PCIe BAR Window Address Translator

This block sits behind the inbound side of a PCIe endpoint. It turns memory reads and writes that land in a 64 MB BAR window into accesses on a 38-bit internal memory address space. The window is cut into sixteen 4 MB pages. Each page has its own 20-bit descriptor, and software programs the descriptors through a small register write port. A descriptor gives the upper address bits of the page's target, a cache-allocate hint, a byte-lane reordering mode and a valid bit.

A request carries a 26-bit window-relative address, a read/write flag and 64 bits of write data. The block presents the translated access one cycle later, together with the hint bits and the write data after byte-lane reordering. A request is refused when the window has not been opened through the control register, or when its page descriptor is invalid. A refused request reaches no memory: it raises a one-cycle error flag, and a refused read is answered with all-ones data. Read data coming back from memory is reordered with the mode of the read that fetched it. Only one read may be outstanding at a time.

Top module: `bar_window_xlate`

## Requirements
- R1: After reset the window is closed and all 16 descriptors are zero, so every page is invalid. mem_valid_o, err_o and rsp_valid_o are low.
- R2: While the window-enable bit (bit 0 of the control write) is 0, a request produces no memory access. It sets err_o for one cycle, and a read also returns rsp_valid_o with rsp_rdata_o all ones in that same cycle. A control write takes effect from the next cycle.
- R3: An accepted request appears on the memory side one cycle after it is sampled. Request address bits [25:22] pick the descriptor. mem_addr_o[37:22] is that descriptor's bits [19:4], and mem_addr_o[21:0] equals request address bits [21:0]. mem_write_o repeats the request's direction.
- R4: mem_cache_o carries descriptor bit 3 and mem_swap_o carries descriptor bits [2:1] of the page used. Descriptor bit 0 is the page-valid flag.
- R5: A request to an open window whose descriptor has bit 0 clear produces no memory access and sets err_o for one cycle. A read additionally returns rsp_valid_o with all-ones data in that cycle.
- R6: Write data is reordered by the page's swap mode. Mode 00 passes it unchanged. Mode 01 reverses all 8 bytes of the 64-bit word. Mode 10 exchanges the two 32-bit halves. Mode 11 reverses the 4 bytes inside each 32-bit half.
- R7: When mem_rvalid_i is high, rsp_valid_o is high one cycle later. rsp_rdata_o is mem_rdata_i reordered by the swap mode of the most recently accepted read.
- R8: A descriptor write (index on tbl_idx_i, value on tbl_data_i) takes effect from the cycle after its strobe. A request in the same cycle as a write to its own page uses the old descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_we_i | input | 1 | Control register write strobe |
| ctl_open_i | input | 1 | Window-enable value written by ctl_we_i |
| tbl_we_i | input | 1 | Descriptor write strobe |
| tbl_idx_i | input | 4 | Descriptor index to write |
| tbl_data_i | input | 20 | Descriptor value to write |
| req_valid_i | input | 1 | Request present |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 26 | Window-relative byte address |
| req_wdata_i | input | 64 | Write data as received |
| mem_valid_o | output | 1 | Translated access present |
| mem_write_o | output | 1 | Direction of the access |
| mem_addr_o | output | 38 | Translated internal address |
| mem_cache_o | output | 1 | Cache-allocate hint of the page |
| mem_swap_o | output | 2 | Swap mode of the page |
| mem_wdata_o | output | 64 | Reordered write data |
| mem_rvalid_i | input | 1 | Read data returned from memory |
| mem_rdata_i | input | 64 | Returned read data |
| rsp_valid_o | output | 1 | Read response to the requester |
| rsp_rdata_o | output | 64 | Read response data |
| err_o | output | 1 | One-cycle flag for a refused request |

## Verification
Translation is tried with directed requests to the first and last pages at the lowest and highest offsets. These show whether the page-select bits and the offset bits are split at the right place. The tests then repeat with the descriptor rewritten in the same cycle as the request, which separates old-value from new-value lookup. Each of the four swap modes is driven with a byte-distinct pattern on both the write path and the read-return path, so any lane routed to the wrong place shows up. A long random mix then interleaves descriptor writes, window open and close, valid and invalid pages, reads and writes, and compares every output against a reference model.

// File: rtl/bwx_pkg.sv
// Package: shared byte-lane reordering codes for the BAR window translator.
// Assumes a 2-bit mode field in each page descriptor.
package bwx_pkg;
    typedef enum logic [1:0] {
        SWAP_NONE  = 2'b00,
        SWAP_BYTE8 = 2'b01,
        SWAP_HALF  = 2'b10,
        SWAP_BYTE4 = 2'b11
    } swap_mode_t;
endpackage

// File: rtl/bwx_lane_swap.sv
// Module: bwx_lane_swap
// Combinational byte-lane reordering of a data word, applied independently
// to every 64-bit slice. Assumes DATA_W is a multiple of 64.
module bwx_lane_swap #(
    parameter int DATA_W = 64
) (
    input  logic [1:0]        mode_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [DATA_W-1:0] data_o
);
    import bwx_pkg::*;
    localparam int NBYTES = DATA_W / 8;

    logic [DATA_W-1:0] rev8, half, rev4;

    // Build each candidate ordering lane by lane.
    for (genvar b = 0; b < NBYTES; b++) begin : g_lane
        localparam int BASE = (b / 8) * 8;
        localparam int R    = b % 8;
        localparam int S8   = BASE + 7 - R;
        localparam int SH   = BASE + (R ^ 4);
        localparam int S4   = BASE + (R & 4) + 3 - (R & 3);
        assign rev8[b*8 +: 8] = data_i[S8*8 +: 8];
        assign half[b*8 +: 8] = data_i[SH*8 +: 8];
        assign rev4[b*8 +: 8] = data_i[S4*8 +: 8];
    end

    // Select the ordering named by the mode.
    always_comb begin
        unique case (swap_mode_t'(mode_i))
            SWAP_BYTE8: data_o = rev8;
            SWAP_HALF:  data_o = half;
            SWAP_BYTE4: data_o = rev4;
            default:    data_o = data_i;
        endcase
    end
endmodule

// File: rtl/bwx_page_table.sv
// Module: bwx_page_table
// Holds the page descriptors: one write port and one combinational read port.
// A write lands at the clock edge, so a same-cycle read sees the old value.
module bwx_page_table #(
    parameter int PAGES   = 16,
    parameter int ENTRY_W = 20
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we_i,
    input  logic [$clog2(PAGES)-1:0] widx_i,
    input  logic [ENTRY_W-1:0]       wdata_i,
    input  logic [$clog2(PAGES)-1:0] ridx_i,
    output logic [ENTRY_W-1:0]       rdata_o
);
    localparam int SEL_W = $clog2(PAGES);

    logic [ENTRY_W-1:0] entry_q [PAGES];

    // One register per page: cleared by reset, loaded by a matching write.
    for (genvar p = 0; p < PAGES; p++) begin : g_page
        always_ff @(posedge clk) begin
            if (!rst_n)
                entry_q[p] <= '0;
            else if (we_i && widx_i == SEL_W'(p))
                entry_q[p] <= wdata_i;
        end
    end

    // Read port: return the selected descriptor.
    assign rdata_o = entry_q[ridx_i];

    // R8: a write is visible through the read port from the next cycle.
    p_write_lands_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && ridx_i == widx_i) |=> (rdata_o == $past(wdata_i) || $past(ridx_i) != ridx_i));
endmodule

// File: rtl/bar_window_xlate.sv
// Module: bar_window_xlate (top)
// Translates window-relative PCIe request addresses into internal addresses
// through a paged descriptor table; refuses requests to a closed window or an
// invalid page. Assumes at most one read is outstanding towards memory.
module bar_window_xlate #(
    parameter int PAGES     = 16,
    parameter int PAGE_BITS = 22,
    parameter int BASE_W    = 16,
    parameter int DATA_W    = 64
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             ctl_we_i,
    input  logic                             ctl_open_i,
    input  logic                             tbl_we_i,
    input  logic [$clog2(PAGES)-1:0]         tbl_idx_i,
    input  logic [BASE_W+3:0]                tbl_data_i,
    input  logic                             req_valid_i,
    input  logic                             req_write_i,
    input  logic [PAGE_BITS+$clog2(PAGES)-1:0] req_addr_i,
    input  logic [DATA_W-1:0]                req_wdata_i,
    output logic                             mem_valid_o,
    output logic                             mem_write_o,
    output logic [BASE_W+PAGE_BITS-1:0]      mem_addr_o,
    output logic                             mem_cache_o,
    output logic [1:0]                       mem_swap_o,
    output logic [DATA_W-1:0]                mem_wdata_o,
    input  logic                             mem_rvalid_i,
    input  logic [DATA_W-1:0]                mem_rdata_i,
    output logic                             rsp_valid_o,
    output logic [DATA_W-1:0]                rsp_rdata_o,
    output logic                             err_o
);
    localparam int SEL_W   = $clog2(PAGES);
    localparam int REQ_AW  = PAGE_BITS + SEL_W;
    localparam int ENTRY_W = BASE_W + 4;

    logic               open_q;
    logic [ENTRY_W-1:0] ent;
    logic [SEL_W-1:0]   sel;
    logic               hit, miss;
    logic [1:0]         rd_mode_q;
    logic [DATA_W-1:0]  wdata_sw, rdata_sw;

    assign sel = req_addr_i[REQ_AW-1:PAGE_BITS];

    bwx_page_table #(.PAGES(PAGES), .ENTRY_W(ENTRY_W)) u_table (
        .clk(clk), .rst_n(rst_n),
        .we_i(tbl_we_i), .widx_i(tbl_idx_i), .wdata_i(tbl_data_i),
        .ridx_i(sel), .rdata_o(ent)
    );

    bwx_lane_swap #(.DATA_W(DATA_W)) u_wswap (
        .mode_i(ent[2:1]), .data_i(req_wdata_i), .data_o(wdata_sw)
    );

    bwx_lane_swap #(.DATA_W(DATA_W)) u_rswap (
        .mode_i(rd_mode_q), .data_i(mem_rdata_i), .data_o(rdata_sw)
    );

    assign hit  = req_valid_i && open_q && ent[0];
    assign miss = req_valid_i && !hit;

    // Window-enable control register.
    always_ff @(posedge clk) begin
        if (!rst_n)        open_q <= 1'b0;
        else if (ctl_we_i) open_q <= ctl_open_i;
    end

    // Issue stage: register the translated access or the refusal flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_valid_o <= 1'b0;
            mem_write_o <= 1'b0;
            mem_addr_o  <= '0;
            mem_cache_o <= 1'b0;
            mem_swap_o  <= 2'b00;
            mem_wdata_o <= '0;
            err_o       <= 1'b0;
            rd_mode_q   <= 2'b00;
        end else begin
            mem_valid_o <= hit;
            err_o       <= miss;
            if (hit) begin
                mem_write_o <= req_write_i;
                mem_addr_o  <= {ent[ENTRY_W-1:4], req_addr_i[PAGE_BITS-1:0]};
                mem_cache_o <= ent[3];
                mem_swap_o  <= ent[2:1];
                mem_wdata_o <= wdata_sw;
                if (!req_write_i) rd_mode_q <= ent[2:1];
            end
        end
    end

    // Response stage: all-ones for a refused read, else reordered memory data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid_o <= 1'b0;
            rsp_rdata_o <= '0;
        end else if (miss && !req_write_i) begin
            rsp_valid_o <= 1'b1;
            rsp_rdata_o <= '1;
        end else if (mem_rvalid_i) begin
            rsp_valid_o <= 1'b1;
            rsp_rdata_o <= rdata_sw;
        end else begin
            rsp_valid_o <= 1'b0;
        end
    end

    // R5: a refused request never reaches memory.
    p_no_access_on_miss_r5: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !mem_valid_o);
    // R5: the error flag only follows a request.
    p_err_needs_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> $past(req_valid_i));
    // R5: a refused read is answered with all-ones data.
    p_miss_read_ones_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && !$past(req_write_i)) |-> (rsp_valid_o && (&rsp_rdata_o)));
    // R3: the in-page offset passes through unchanged.
    p_offset_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid_o |-> mem_addr_o[PAGE_BITS-1:0] == $past(req_addr_i[PAGE_BITS-1:0]));
    // R2: no access leaves a closed window.
    p_closed_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid_o |-> $past(open_q));
    // R7: read data is answered in the following cycle.
    p_read_return_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rvalid_i |=> rsp_valid_o);
endmodule

// File: tb/tb_bar_window_xlate.sv
module tb_bar_window_xlate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_we_i = 0, ctl_open_i = 0, tbl_we_i = 0;
    logic [3:0]  tbl_idx_i = 0;
    logic [19:0] tbl_data_i = 0;
    logic        req_valid_i = 0, req_write_i = 0;
    logic [25:0] req_addr_i = 0;
    logic [63:0] req_wdata_i = 0;
    logic        mem_valid_o, mem_write_o, mem_cache_o;
    logic [37:0] mem_addr_o;
    logic [1:0]  mem_swap_o;
    logic [63:0] mem_wdata_o;
    logic        mem_rvalid_i = 0;
    logic [63:0] mem_rdata_i = 0;
    logic        rsp_valid_o, err_o;
    logic [63:0] rsp_rdata_o;

    int checks = 0, fails = 0;
    logic [19:0] mdl_tbl [16];
    logic        mdl_open;
    logic [1:0]  mdl_rd_mode;
    bit          done = 0;

    always #2 clk = ~clk;   // 250 MHz

    bar_window_xlate dut (.*);

    function automatic logic [63:0] ref_swap(input logic [1:0] m, input logic [63:0] d);
        logic [63:0] o;
        o = d;
        case (m)
            2'b01: for (int i = 0; i < 8; i++) o[i*8 +: 8] = d[(7-i)*8 +: 8];
            2'b10: o = {d[31:0], d[63:32]};
            2'b11: for (int i = 0; i < 4; i++) begin
                       o[i*8 +: 8]      = d[(3-i)*8 +: 8];
                       o[32+i*8 +: 8]   = d[32+(3-i)*8 +: 8];
                   end
            default: o = d;
        endcase
        return o;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One cycle: drive at negedge, compare after the edge, then update the model.
    task automatic step(input bit rv, input bit wr, input logic [25:0] a, input logic [63:0] wd,
                        input bit twe, input logic [3:0] ti, input logic [19:0] td,
                        input bit cwe, input bit cop);
        logic [19:0] e;
        bit exp_hit;
        string tag;
        @(negedge clk);
        req_valid_i = rv; req_write_i = wr; req_addr_i = a; req_wdata_i = wd;
        tbl_we_i = twe; tbl_idx_i = ti; tbl_data_i = td;
        ctl_we_i = cwe; ctl_open_i = cop;
        e = mdl_tbl[a[25:22]];
        exp_hit = rv && mdl_open && e[0];
        tag = !mdl_open ? "R2" : (!e[0] ? "R5" : "R3");
        if (twe && ti == a[25:22]) tag = {tag, "/R8"};
        @(posedge clk); #1;
        chk({tag, " mem_valid"}, 64'(mem_valid_o), 64'(exp_hit));
        chk({tag, " err"}, 64'(err_o), 64'(rv && !exp_hit));
        if (exp_hit) begin
            chk({tag, " R3 addr"}, 64'(mem_addr_o), 64'({e[19:4], a[21:0]}));
            chk({tag, " R3 write"}, 64'(mem_write_o), 64'(wr));
            chk({tag, " R4 cache"}, 64'(mem_cache_o), 64'(e[3]));
            chk({tag, " R4 swap"}, 64'(mem_swap_o), 64'(e[2:1]));
            if (wr) chk({tag, " R6 wdata"}, mem_wdata_o, ref_swap(e[2:1], wd));
            else mdl_rd_mode = e[2:1];
        end
        if (rv && !exp_hit && !wr) begin
            chk({tag, " rsp_valid"}, 64'(rsp_valid_o), 64'd1);
            chk({tag, " rsp all-ones"}, rsp_rdata_o, '1);
        end else begin
            chk({tag, " no rsp"}, 64'(rsp_valid_o), 64'd0);
        end
        if (twe) mdl_tbl[ti] = td;
        if (cwe) mdl_open = cop;
        req_valid_i = 0; tbl_we_i = 0; ctl_we_i = 0;
    endtask

    task automatic ret(input logic [63:0] d);
        @(negedge clk);
        mem_rvalid_i = 1; mem_rdata_i = d;
        @(posedge clk); #1;
        chk("R7 rsp_valid", 64'(rsp_valid_o), 64'd1);
        chk("R7 rsp data", rsp_rdata_o, ref_swap(mdl_rd_mode, d));
        mem_rvalid_i = 0;
    endtask

    task automatic twr(input logic [3:0] i, input logic [19:0] d);
        step(0, 0, '0, '0, 1, i, d, 0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [63:0] pat;
        pat = 64'h0102030405060708;
        for (int i = 0; i < 16; i++) mdl_tbl[i] = '0;
        mdl_open = 0; mdl_rd_mode = 0;
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        #1;
        chk("R1 mem_valid", 64'(mem_valid_o), 0);
        chk("R1 err", 64'(err_o), 0);
        chk("R1 rsp_valid", 64'(rsp_valid_o), 0);
        // R1: every page invalid after reset, even once the window opens
        step(0, 0, '0, '0, 0, 0, 0, 1, 1);
        step(1, 0, {4'd7, 22'h1234}, '0, 0, 0, 0, 0, 0);
        step(0, 0, '0, '0, 0, 0, 0, 1, 0);
        // R2: closed window refuses a valid page
        twr(4'd0, {16'hABCD, 1'b1, 2'b00, 1'b1});
        step(1, 0, {4'd0, 22'h0}, '0, 0, 0, 0, 0, 0);
        step(1, 1, {4'd0, 22'h0}, pat, 0, 0, 0, 1, 1);   // R2: open lands next cycle
        step(1, 0, {4'd0, 22'h0}, '0, 0, 0, 0, 0, 0);
        ret(pat);
        // R3: last page, highest offset
        twr(4'd15, {16'h8001, 1'b0, 2'b01, 1'b1});
        step(1, 0, {4'd15, 22'h3FFFFF}, '0, 0, 0, 0, 0, 0);
        ret(pat);                                         // R7 with mode 01
        // R6: each swap mode on the write path, R7 on read path
        for (int m = 0; m < 4; m++) begin
            twr(4'd5, {16'h0F00 + 16'(m), 1'(m), 2'(m), 1'b1});
            step(1, 1, {4'd5, 22'h2A5A5}, pat, 0, 0, 0, 0, 0);
            step(1, 0, {4'd5, 22'h00010}, '0, 0, 0, 0, 0, 0);
            ret(64'hF0E1D2C3B4A59687);
        end
        // R8: same-cycle rewrite of the page used: old value applies
        step(1, 1, {4'd5, 22'h11}, pat, 1, 4'd5, {16'h7777, 1'b0, 2'b10, 1'b1}, 0, 0);
        step(1, 1, {4'd5, 22'h11}, pat, 1, 4'd5, 20'h0, 0, 0);
        step(1, 0, {4'd5, 22'h11}, '0, 0, 0, 0, 0, 0);   // R5: now invalid
        step(1, 1, {4'd5, 22'h11}, pat, 0, 0, 0, 0, 0);  // R5 write refused
        // random mix
        for (int k = 0; k < 600; k++) begin
            bit rv, wr, twe, cwe;
            rv  = ($urandom % 4) != 0;
            wr  = $urandom % 2;
            twe = ($urandom % 3) == 0;
            cwe = ($urandom % 16) == 0;
            step(rv, wr, 26'($urandom), {$urandom, $urandom}, twe, 4'($urandom),
                 20'($urandom) | 20'(($urandom % 5) != 0), cwe, ($urandom % 4) != 0);
            if (rv && !wr && mem_valid_o) ret({$urandom, $urandom});
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule